// File: doc/BRIEF.md
# Supply Event Recorder for a Battery-Backed Clock

This block sits beside the calendar of a battery-backed timekeeper and turns digitized supply comparator flags into host-visible state. It receives four asynchronous level flags: main supply below its brown-out trip, device running from battery, battery below 85 % of nominal, and battery below 75 % of nominal. It also receives the running time/date bus from the calendar. Each flag is synchronized before use.

The block keeps a sticky brown-out flag that also drives an active-low low-voltage reset output. It reports the battery levels and the present supply source. It captures two timestamps. The "went to battery" bank keeps the first switchover until the host erases it. The "back on supply" bank always holds the most recent return to the main supply.

A host reads and writes the registers through single-cycle strobes. Register 0 is status. Registers 1..TS_BYTES hold the to-battery bank. Registers TS_BYTES+1..2*TS_BYTES hold the to-supply bank. Byte k of either bank is calendar byte `now_time[8k+7:8k]`.

Top module: `pwr_event_rec`

## Requirements
- R1: A brown-out flag (status bit 0) sets on the third rising clock edge after `brownout_in` rises, and stays set for as long as `brownout_in` stays high, even across status reads.
- R2: `lv_rst_n` is low in every cycle that the brown-out flag is set, and high otherwise.
- R3: A read of address 0 returns the brown-out flag as it was before the read, then clears it, unless the synchronized brown-out input is still high. A second read after the supply recovers returns bit 0 = 0.
- R4: Status bit 1 means "battery below 85 %" and bit 2 means "battery below 75 %". Between the two levels, only bit 1 is set. Below 75 %, both bits read 1, even if only the 75 % flag is asserted.
- R5: Status bit 3 follows the synchronized on-battery flag, and status bits 7..4 read 0.
- R6: On a synchronized rising edge of `on_batt_in`, `now_time` is copied into the to-battery bank (addresses 1..TS_BYTES), but only when every byte of that bank is 00h.
- R7: While any to-battery byte is non-zero, further switchovers to battery leave that bank unchanged.
- R8: A write of 00h to a timestamp address clears that single byte. A write of any other value to a timestamp address changes nothing.
- R9: On a synchronized falling edge of `on_batt_in`, `now_time` is copied into the to-supply bank (addresses TS_BYTES+1..2*TS_BYTES), replacing whatever it held.
- R10: `rdata` is registered and presents the addressed byte one cycle after `rd_stb`. Addresses above 2*TS_BYTES read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brownout_in | input | 1 | Supply below brown-out trip (asynchronous) |
| on_batt_in | input | 1 | Device switched onto battery (asynchronous) |
| batt_lo85_in | input | 1 | Battery below 85 % of nominal (asynchronous) |
| batt_lo75_in | input | 1 | Battery below 75 % of nominal (asynchronous) |
| now_time | input | 8*TS_BYTES | Current time/date bytes from the calendar |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| addr | input | $clog2(2*TS_BYTES+1) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lv_rst_n | output | 1 | Active-low low-voltage reset |

## Verification
A stuck or wrongly cleared brown-out flag shows at once on `lv_rst_n`, and on the next status read. A wrong "empty" decision in the to-battery bank shows only on a later switchover: a lost first timestamp, or a capture that overwrites one. The bench therefore repeats switchovers after partial and full erasure. A missed edge in the synchronizer chain shows as a timestamp that is one calendar value off, or absent. For that reason the calendar bus is changed between events, so every capture is tied to a distinct value.

// File: rtl/pwr_event_pkg.sv
package pwr_event_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [3:0] zero;
      logic       on_batt;
      logic       lo75;
      logic       lo85;
      logic       brownout;
   } pwr_status_t;

   // index of each flag inside the synchronized vector
   localparam int IDX_BO  = 0;
   localparam int IDX_BAT = 1;
   localparam int IDX_L85 = 2;
   localparam int IDX_L75 = 3;
   localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pwr_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwr_ts_bank.sv
module pwr_ts_bank #(
   parameter int NBYTES     = 6,
   parameter bit KEEP_FIRST = 1'b1,
   localparam int TW        = NBYTES * pwr_event_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_evt,
   input  logic [TW-1:0]     now,
   input  logic [NBYTES-1:0] clr_en,
   output logic [TW-1:0]     ts,
   output logic              empty
);
   generate
      if (NBYTES < 1) begin : g_bad_n
         $error("pwr_ts_bank: NBYTES must be at least 1");
      end
   endgenerate

   logic cap_ok;

   assign empty = (ts == '0);

   generate
      if (KEEP_FIRST) begin : g_first
         assign cap_ok = cap_evt & empty;

         // R7
         hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!empty && clr_en == '0) |=> $stable(ts));
      end else begin : g_last
         assign cap_ok = cap_evt;

         // R9
         latest_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_evt |=> (ts == $past(now)));
      end

      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ts[k*8 +: 8] <= '0;
            else if (cap_ok)
               ts[k*8 +: 8] <= now[k*8 +: 8];
            else if (clr_en[k])
               ts[k*8 +: 8] <= '0;
         end
      end
   endgenerate
endmodule

// File: rtl/pwr_event_rec.sv
module pwr_event_rec #(
   parameter int TS_BYTES    = 6,
   parameter int SYNC_STAGES = 2,
   localparam int TS_W       = TS_BYTES * pwr_event_pkg::BYTE_W,
   localparam int NUM_REGS   = 2 * TS_BYTES + 1,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brownout_in,
   input  logic              on_batt_in,
   input  logic              batt_lo85_in,
   input  logic              batt_lo75_in,
   input  logic [TS_W-1:0]   now_time,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              lv_rst_n
);
   import pwr_event_pkg::*;

   generate
      if (TS_BYTES < 1) begin : g_bad_bytes
         $error("pwr_event_rec: TS_BYTES must be at least 1");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] raw_flags, flg;
   logic                 bat_d;
   logic                 to_batt, to_supply;
   logic                 bo_flag;
   logic                 rd_status;
   pwr_status_t          st;
   logic [TS_W-1:0]      dn_ts, up_ts;
   logic                 dn_empty, up_empty;
   logic [TS_BYTES-1:0]  dn_clr, up_clr;
   logic [7:0]           rd_val;

   assign raw_flags[IDX_BO]  = brownout_in;
   assign raw_flags[IDX_BAT] = on_batt_in;
   assign raw_flags[IDX_L85] = batt_lo85_in;
   assign raw_flags[IDX_L75] = batt_lo75_in;

   pwr_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_flags),
      .q_sync  (flg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bat_d <= 1'b0;
      else        bat_d <= flg[IDX_BAT];
   end

   assign to_batt   =  flg[IDX_BAT] & ~bat_d;
   assign to_supply = ~flg[IDX_BAT] &  bat_d;

   assign rd_status = rd_stb && (addr == '0);

   // sticky brown-out: a set in the same cycle wins over a read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               bo_flag <= 1'b0;
      else if (flg[IDX_BO])     bo_flag <= 1'b1;
      else if (rd_status)       bo_flag <= 1'b0;
   end

   assign lv_rst_n = ~bo_flag;

   // R1
   bo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flg[IDX_BO] |=> bo_flag);

   // R3
   bo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !flg[IDX_BO]) |=> !bo_flag);

   always_comb begin
      st          = '0;
      st.brownout = bo_flag;
      st.lo85     = flg[IDX_L85] | flg[IDX_L75];
      st.lo75     = flg[IDX_L75];
      st.on_batt  = flg[IDX_BAT];
   end

   generate
      for (genvar k = 0; k < TS_BYTES; k++) begin : g_clr
         assign dn_clr[k] = wr_stb && (wdata == 8'h00) && (addr == ADDR_W'(k + 1));
         assign up_clr[k] = wr_stb && (wdata == 8'h00) && (addr == ADDR_W'(TS_BYTES + 1 + k));
      end
   endgenerate

   pwr_ts_bank #(.NBYTES(TS_BYTES), .KEEP_FIRST(1'b1)) u_dn_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_evt (to_batt),
      .now     (now_time),
      .clr_en  (dn_clr),
      .ts      (dn_ts),
      .empty   (dn_empty)
   );

   pwr_ts_bank #(.NBYTES(TS_BYTES), .KEEP_FIRST(1'b0)) u_up_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_evt (to_supply),
      .now     (now_time),
      .clr_en  (up_clr),
      .ts      (up_ts),
      .empty   (up_empty)
   );

   always_comb begin
      rd_val = 8'h00;
      if (addr == '0) rd_val = st;
      for (int k = 0; k < TS_BYTES; k++) begin
         if (addr == ADDR_W'(k + 1))            rd_val = dn_ts[k*8 +: 8];
         if (addr == ADDR_W'(TS_BYTES + 1 + k)) rd_val = up_ts[k*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= 8'h00;
      else if (rd_stb) rdata <= rd_val;
   end

   // R7: a full to-battery bank only holds or shrinks, so it never reads empty then full without a capture
   dn_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dn_empty) && !dn_empty) |-> $past(to_batt));

   // up_empty is reported only for symmetry of the bank instance
   up_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_empty) && !up_empty) |-> $past(to_supply));
endmodule

// File: tb/pwr_event_rec_tb_top.sv
module pwr_event_rec_tb_top;
   localparam int NB = 6;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          brownout_in = 0, on_batt_in = 0, batt_lo85_in = 0, batt_lo75_in = 0;
   logic [NB*8-1:0] now_time = '0;
   logic          rd_stb = 0, wr_stb = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          lv_rst_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic  rd_pend = 0;
   logic [7:0] exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   pwr_event_rec #(.TS_BYTES(NB), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .brownout_in(brownout_in), .on_batt_in(on_batt_in),
      .batt_lo85_in(batt_lo85_in), .batt_lo75_in(batt_lo75_in),
      .now_time(now_time),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lv_rst_n(lv_rst_n)
   );

   // monitor: a read issued before an edge is compared at the following negedge
   always @(posedge clk) rd_pend <= rd_stb;

   always @(negedge clk) begin
      if (rd_pend && exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
         end
      end
   end

   function automatic logic [7:0] bsel(logic [NB*8-1:0] t, int k);
      return t[k*8 +: 8];
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_read(logic [AW-1:0] a, logic [7:0] e, string t);
      addr = a; rd_stb = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
      addr = a; wdata = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic check_bit(logic got, logic e, string t);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s: got=%0b expected=%0b", t, got, e);
      end
   endtask

   task automatic read_bank(int base, logic [NB*8-1:0] v, string t);
      for (int k = 0; k < NB; k++) bus_read(AW'(base + k), bsel(v, k), t);
   endtask

   localparam logic [NB*8-1:0] T1 = 48'h24_0C_1F_17_3B_2A;
   localparam logic [NB*8-1:0] T2 = 48'h25_01_02_03_04_05;
   localparam logic [NB*8-1:0] T3 = 48'h26_07_08_09_0A_0B;
   localparam logic [NB*8-1:0] T4 = 48'h27_11_12_13_14_15;
   localparam logic [NB*8-1:0] T5 = 48'h28_21_22_23_24_25;

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // reset state
      check_bit(lv_rst_n, 1'b1, "R2 reset");
      bus_read(0, 8'h00, "R1 reset status");
      bus_read(1, 8'h00, "R6 reset bank");
      bus_read(15, 8'h00, "R10 unmapped");

      // brown-out: set after three edges
      brownout_in = 1'b1;
      tick(2);
      check_bit(lv_rst_n, 1'b1, "R1 not yet set");
      tick(1);
      check_bit(lv_rst_n, 1'b0, "R2 low after brown-out");
      bus_read(0, 8'h01, "R1 flag set");
      bus_read(0, 8'h01, "R3 set wins over read clear");
      brownout_in = 1'b0;
      tick(4);
      check_bit(lv_rst_n, 1'b0, "R1 sticky after recovery");
      bus_read(0, 8'h01, "R3 read returns old flag");
      bus_read(0, 8'h00, "R3 cleared by read");
      check_bit(lv_rst_n, 1'b1, "R2 released");

      // battery levels
      batt_lo85_in = 1'b1; tick(4);
      bus_read(0, 8'h02, "R4 between levels");
      batt_lo75_in = 1'b1; tick(4);
      bus_read(0, 8'h06, "R4 below 75");
      batt_lo85_in = 1'b0; tick(4);
      bus_read(0, 8'h06, "R4 75 alone forces 85");
      batt_lo75_in = 1'b0; tick(4);
      bus_read(0, 8'h00, "R4 levels clear");

      // first switchover to battery
      now_time = T1;
      on_batt_in = 1'b1; tick(4);
      bus_read(0, 8'h08, "R5 on battery");
      read_bank(1, T1, "R6 first capture");
      now_time = T2;
      on_batt_in = 1'b0; tick(4);
      bus_read(0, 8'h00, "R5 on supply");
      read_bank(NB + 1, T2, "R9 return capture");

      // second switchover: first value kept
      now_time = T3;
      on_batt_in = 1'b1; tick(4);
      read_bank(1, T1, "R7 first kept");

      // non-zero write ignored, zero write clears one byte
      bus_write(1, 8'h55);
      bus_read(1, bsel(T1, 0), "R8 nonzero write ignored");
      bus_write(1, 8'h00);
      read_bank(1, {T1[NB*8-1:8], 8'h00}, "R8 single byte cleared");

      // return: latest overwrites; switch again with partial bank
      now_time = T4;
      on_batt_in = 1'b0; tick(4);
      read_bank(NB + 1, T4, "R9 overwrite latest");
      now_time = T5;
      on_batt_in = 1'b1; tick(4);
      read_bank(1, {T1[NB*8-1:8], 8'h00}, "R7 partial bank not recaptured");

      // erase remaining bytes, then capture again
      for (int k = 2; k <= NB; k++) bus_write(AW'(k), 8'h00);
      read_bank(1, '0, "R8 bank erased");
      bus_write(AW'(NB + 1), 8'h00);
      bus_read(AW'(NB + 1), 8'h00, "R8 up bank byte cleared");
      bus_read(AW'(NB + 2), bsel(T4, 1), "R8 neighbour byte kept");
      on_batt_in = 1'b0; tick(4);
      on_batt_in = 1'b1; tick(4);
      read_bank(1, T5, "R6 capture after erase");
      bus_read(AW'(2 * NB + 1), 8'h00, "R10 above range");

      tick(3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule